// File: doc/BRIEF.md
# Seed Dispatch Scheduler with Alert Supervisor

This block feeds an array of identical search units, each of which runs from a start value until it reports that it is done. A single pointer walks the array one unit per clock. When the unit under the pointer is idle and asks for work, the block strobes that unit's load line and puts the current seed on a shared start bus. It then advances a seed counter. Because each load takes a fresh count, no two units ever start from the same value.

The same walk also supervises the units. A unit that stops with a suspected failure (a value overflow or a step-count timeout) raises an alert. When the pointer reaches an alerted unit, the block reads that unit's start value back through a select/readback pair. It presents the value, with a one-bit reason, on a valid/ready output stream. Once the stream accepts the word, the block pulses the unit's clear line. The stream follows the usual back-pressure rules. While `out_valid` is high and `out_ready` is low, the word is held unchanged, the pointer stays put and no unit is loaded. The word is consumed only in a cycle where both signals are high.

A barrier mode is also available. In this mode, no unit is reloaded until every unit in the array is ready and none is alerted. One full sweep then hands each unit a distinct seed. The mode and the base seed are taken when `start` pulses.

Top module: `seed_dispatch`

## Requirements
- R1: After reset, and until the first `start` pulse, `unit_load`, `unit_clear` and `out_valid` stay low.
- R2: A `start` pulse loads the seed counter from `base_seed` and latches `mode_group`. No unit is loaded in the cycle `start` is high, and the next load carries `base_seed`.
- R3: While running, the pointer visits unit indices in ascending order, one per cycle, and wraps from N-1 to 0. It holds only while an alert word waits on the stream. At most one load bit is high in any cycle.
- R4: Each load carries the seed of the previous load plus one, modulo 2^SEED_W, so consecutive loads carry distinct values.
- R5: A selected unit whose alert is high is serviced instead of being loaded. The next cycle brings `out_valid` high, with `out_seed` equal to that unit's `sel_seed` and `out_kind` equal to its `unit_alert_kind` bit (1 = timeout, 0 = overflow).
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_seed` and `out_kind` hold, and no unit is loaded or cleared.
- R7: `unit_clear` is a one-cycle one-hot pulse for the alerted unit, high exactly in the cycle of the stream handshake. The pointer then moves to the next index.
- R8: In barrier mode, no unit is loaded while any unit is not ready or any alert is high. Once all units are ready, the following sweep loads every unit exactly once, and then the barrier closes again.
- R9: A load only targets a unit whose ready line is high and whose alert line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse: take base seed and mode, begin running |
| mode_group | input | 1 | 0 = per-unit dispatch, 1 = barrier mode |
| base_seed | input | SEED_W | First seed handed out after start |
| unit_ready | input | N_UNITS | Unit is idle and wants a seed |
| unit_alert | input | N_UNITS | Unit stopped on a suspected failure |
| unit_alert_kind | input | N_UNITS | Alert reason, 1 = timeout, 0 = overflow |
| unit_load | output | N_UNITS | One-hot load strobe |
| unit_start | output | SEED_W | Seed presented with the load strobe |
| unit_sel | output | IDX_W | Index of the unit under the pointer |
| sel_seed | input | SEED_W | Start value of the unit chosen by `unit_sel` |
| unit_clear | output | N_UNITS | One-hot alert clear strobe |
| out_valid | output | 1 | Alert word available |
| out_ready | input | 1 | Consumer accepts the alert word |
| out_seed | output | SEED_W | Start value behind the alert |
| out_kind | output | 1 | Alert reason, 1 = timeout, 0 = overflow |

## Verification
On every cycle, the assertions check the following: loads are one-hot and aimed only at ready, non-alerted units, consecutive loads step the seed by one, the alert word holds under back-pressure, clears coincide with a handshake, and nothing moves before the first start. The bench scenarios cover what needs a longer history. They confirm the exact order of indices and seeds across a sweep, seed wrap-around at the counter width, and the priority of an alert over a ready request on the same unit. They also confirm that a cleared unit is reloaded on a later pass, and that barrier mode waits for the whole array before loading each unit once.

// File: rtl/seed_dispatch_pkg.sv
package seed_dispatch_pkg;
  typedef enum logic [0:0] {
    ST_SCAN = 1'b0,
    ST_HOLD = 1'b1
  } sched_state_e;

  localparam logic KIND_OVERFLOW = 1'b0;
  localparam logic KIND_TIMEOUT  = 1'b1;
endpackage

// File: rtl/sd_rr_ptr.sv
module sd_rr_ptr #(
  parameter int N_UNITS = 400,
  localparam int IDX_W = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_UNITS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (step) begin
      ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  end
endmodule

// File: rtl/sd_seed_ctr.sv
module sd_seed_ctr #(
  parameter int SEED_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              preset,
  input  logic [SEED_W-1:0] preset_val,
  input  logic              bump,
  output logic [SEED_W-1:0] seed
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seed <= '0;
    end else if (preset) begin
      seed <= preset_val;
    end else if (bump) begin
      seed <= seed + 1'b1;
    end
  end
endmodule

// File: rtl/sd_barrier.sv
module sd_barrier #(
  parameter int N_UNITS = 400,
  localparam int IDX_W = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic enable,
  input  logic all_ready,
  input  logic any_alert,
  input  logic in_scan,
  input  logic step,
  output logic open
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_UNITS - 1);

  logic [IDX_W-1:0] visits;

  always_ff @(posedge clk) begin
    if (!rst_n || arm) begin
      open   <= 1'b0;
      visits <= '0;
    end else if (!open) begin
      if (enable && all_ready && !any_alert && in_scan) begin
        open   <= 1'b1;
        visits <= '0;
      end
    end else if (step) begin
      if (visits == LAST) begin
        open <= 1'b0;
      end else begin
        visits <= visits + 1'b1;
      end
    end
  end
endmodule

// File: rtl/seed_dispatch.sv
module seed_dispatch
  import seed_dispatch_pkg::*;
#(
  parameter int N_UNITS = 400,
  parameter int SEED_W  = 128,
  localparam int IDX_W  = (N_UNITS > 1) ? $clog2(N_UNITS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               mode_group,
  input  logic [SEED_W-1:0]  base_seed,
  input  logic [N_UNITS-1:0] unit_ready,
  input  logic [N_UNITS-1:0] unit_alert,
  input  logic [N_UNITS-1:0] unit_alert_kind,
  output logic [N_UNITS-1:0] unit_load,
  output logic [SEED_W-1:0]  unit_start,
  output logic [IDX_W-1:0]   unit_sel,
  input  logic [SEED_W-1:0]  sel_seed,
  output logic [N_UNITS-1:0] unit_clear,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [SEED_W-1:0]  out_seed,
  output logic               out_kind
);
  localparam logic [N_UNITS-1:0] ONE_HOT0 = N_UNITS'(1);

  sched_state_e     state;
  logic             running;
  logic             group_q;
  logic [IDX_W-1:0] ptr;
  logic             barrier_open;
  logic             sel_ready;
  logic             sel_alert;
  logic             alert_hit;
  logic             dispatch;
  logic             handshake;
  logic             step;
  logic [N_UNITS-1:0] sel_mask;

  assign sel_mask  = ONE_HOT0 << ptr;
  assign sel_ready = |(unit_ready & sel_mask);
  assign sel_alert = |(unit_alert & sel_mask);

  // Alert on the selected unit outranks a dispatch to it.
  assign alert_hit = running && (state == ST_SCAN) && sel_alert;
  assign dispatch  = running && !start && (state == ST_SCAN) && sel_ready &&
                     !sel_alert && (!group_q || barrier_open);
  assign handshake = (state == ST_HOLD) && out_ready;
  assign step      = running && (((state == ST_SCAN) && !sel_alert) || handshake);

  assign unit_load  = dispatch  ? sel_mask : '0;
  assign unit_clear = handshake ? sel_mask : '0;
  assign unit_sel   = ptr;
  assign out_valid  = (state == ST_HOLD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      group_q <= 1'b0;
    end else if (start) begin
      running <= 1'b1;
      group_q <= mode_group;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_SCAN;
      out_seed <= '0;
      out_kind <= KIND_OVERFLOW;
    end else begin
      case (state)
        ST_SCAN: begin
          if (alert_hit) begin
            state    <= ST_HOLD;
            out_seed <= sel_seed;
            out_kind <= |(unit_alert_kind & sel_mask);
          end
        end
        ST_HOLD: begin
          if (out_ready) begin
            state <= ST_SCAN;
          end
        end
        default: state <= ST_SCAN;
      endcase
    end
  end

  sd_rr_ptr #(.N_UNITS(N_UNITS)) u_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (step),
    .ptr   (ptr)
  );

  sd_seed_ctr #(.SEED_W(SEED_W)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .preset     (start),
    .preset_val (base_seed),
    .bump       (dispatch),
    .seed       (unit_start)
  );

  sd_barrier #(.N_UNITS(N_UNITS)) u_bar (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (start),
    .enable    (running && group_q),
    .all_ready (&unit_ready),
    .any_alert (|unit_alert),
    .in_scan   (state == ST_SCAN),
    .step      (step),
    .open      (barrier_open)
  );
endmodule

// File: rtl/seed_dispatch_chk.sv
module seed_dispatch_chk #(
  parameter int N_UNITS = 400,
  parameter int SEED_W  = 128
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic [N_UNITS-1:0] unit_ready,
  input logic [N_UNITS-1:0] unit_alert,
  input logic [N_UNITS-1:0] unit_load,
  input logic [SEED_W-1:0]  unit_start,
  input logic [N_UNITS-1:0] unit_clear,
  input logic               out_valid,
  input logic               out_ready,
  input logic [SEED_W-1:0]  out_seed,
  input logic               out_kind
);
  logic seen_start;

  always_ff @(posedge clk) begin
    if (!rst_n) seen_start <= 1'b0;
    else if (start) seen_start <= 1'b1;
  end

  // R1
  idle_before_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_start |-> (unit_load == '0 && unit_clear == '0 && !out_valid));

  // R3
  load_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(unit_load));

  // R4
  seed_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|unit_load && !start) |=> (unit_start == SEED_W'($past(unit_start) + 1'b1)));

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_seed) && $stable(out_kind)));

  // R6
  no_load_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (unit_load == '0));

  // R7
  clear_on_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|unit_clear) |-> (out_valid && out_ready && $onehot(unit_clear)));

  // R9
  load_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|unit_load) |-> ((unit_load & ~unit_ready) == '0 && (unit_load & unit_alert) == '0));
endmodule

bind seed_dispatch seed_dispatch_chk #(.N_UNITS(N_UNITS), .SEED_W(SEED_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .unit_ready (unit_ready),
  .unit_alert (unit_alert),
  .unit_load  (unit_load),
  .unit_start (unit_start),
  .unit_clear (unit_clear),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_seed   (out_seed),
  .out_kind   (out_kind)
);

// File: tb/seed_dispatch_test.sv
module seed_dispatch_test;
  localparam int N  = 4;
  localparam int W  = 16;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic mode_group = 1'b0;
  logic [W-1:0] base_seed = '0;
  logic [N-1:0] ready_m, alert_m, kind_m;
  logic [N-1:0] req_ready = '0, req_alert = '0, req_kind = '0;
  logic [N-1:0] unit_load, unit_clear;
  logic [W-1:0] unit_start, sel_seed, out_seed;
  logic [IW-1:0] unit_sel;
  logic out_valid, out_kind;
  logic out_ready = 1'b0;
  logic [W-1:0] seed_m [N];

  int checks = 0, fails = 0, cycles = 0;
  int log_idx [64];
  logic [W-1:0] log_val [64];
  int log_n = 0;

  always #4 clk = ~clk;

  seed_dispatch #(.N_UNITS(N), .SEED_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_group(mode_group),
    .base_seed(base_seed), .unit_ready(ready_m), .unit_alert(alert_m),
    .unit_alert_kind(kind_m), .unit_load(unit_load), .unit_start(unit_start),
    .unit_sel(unit_sel), .sel_seed(sel_seed), .unit_clear(unit_clear),
    .out_valid(out_valid), .out_ready(out_ready), .out_seed(out_seed),
    .out_kind(out_kind)
  );

  assign sel_seed = seed_m[unit_sel];

  // Behavioural model of the unit array
  always @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (!rst_n) begin
        ready_m[i] <= 1'b0; alert_m[i] <= 1'b0; kind_m[i] <= 1'b0; seed_m[i] <= '0;
      end else begin
        ready_m[i] <= (ready_m[i] & ~unit_load[i]) | unit_clear[i] | req_ready[i];
        alert_m[i] <= (alert_m[i] & ~unit_clear[i]) | req_alert[i];
        if (req_alert[i]) kind_m[i] <= req_kind[i];
        if (unit_load[i]) seed_m[i] <= unit_start;
      end
    end
  end

  // Load log sampled away from the active edge
  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (rst_n && |unit_load && log_n < 64) begin
      for (int i = 0; i < N; i++)
        if (unit_load[i]) log_idx[log_n] = i;
      log_val[log_n] = unit_start;
      log_n = log_n + 1;
    end
  end

  always @(negedge clk) begin
    if (cycles > 20000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic pulse_ready(input logic [N-1:0] m);
    req_ready = m; @(negedge clk); req_ready = '0;
  endtask

  task automatic pulse_alert(input logic [N-1:0] m, input logic [N-1:0] k, input logic [N-1:0] r);
    req_alert = m; req_kind = k; req_ready = r;
    @(negedge clk);
    req_alert = '0; req_kind = '0; req_ready = '0;
  endtask

  task automatic do_start(input logic [W-1:0] b, input logic g, input logic [N-1:0] r);
    start = 1'b1; base_seed = b; mode_group = g; req_ready = r;
    @(negedge clk);
    start = 1'b0; req_ready = '0;
  endtask

  task automatic wait_valid();
    for (int k = 0; k < 40 && !out_valid; k++) @(negedge clk);
  endtask

  initial begin
    int n0;
    logic [W-1:0] bases [3];
    logic [N-1:0] seen;
    bases[0] = 16'h0000; bases[1] = 16'h7FFF; bases[2] = 16'hFFFE;

    cyc(3);
    check("R1 reset out_valid", out_valid, 0);
    check("R1 reset load", unit_load, 0);
    check("R1 reset clear", unit_clear, 0);
    rst_n = 1'b1;
    cyc(1);

    // R1: ready units without a start are left alone
    pulse_ready(4'hF);
    cyc(10);
    check("R1 no load before start", log_n, 0);

    // R2 R3 R4: per-unit dispatch in index order
    do_start(16'd100, 1'b0, '0);
    cyc(10);
    check("R3 load count", log_n, 4);
    for (int k = 0; k < 4; k++) begin
      check("R3 index order", log_idx[k], k);
      check("R2 R4 seed value", log_val[k], 100 + k);
    end

    // R9: only the unit that became ready is loaded
    n0 = log_n;
    pulse_ready(4'b0100);
    cyc(8);
    check("R9 single reload count", log_n - n0, 1);
    check("R9 reload index", log_idx[n0], 2);
    check("R4 reload seed", log_val[n0], 104);

    // R5 R6 R7: overflow alert on unit 1 under back-pressure
    out_ready = 1'b0;
    pulse_alert(4'b0010, 4'b0000, 4'b0000);
    wait_valid();
    check("R5 valid raised", out_valid, 1);
    check("R5 seed of alerted unit", out_seed, 101);
    check("R5 kind overflow", out_kind, 0);
    for (int k = 0; k < 4; k++) begin
      cyc(1);
      check("R6 valid held", out_valid, 1);
      check("R6 seed held", out_seed, 101);
      check("R6 no clear under stall", unit_clear, 0);
    end
    out_ready = 1'b1;
    #1;
    check("R7 clear on handshake", unit_clear, 4'b0010);
    n0 = log_n;
    cyc(1);
    check("R7 valid dropped", out_valid, 0);
    check("R7 clear one cycle", unit_clear, 0);
    cyc(8);
    check("R7 cleared unit reloaded", log_n - n0, 1);
    check("R7 reload index", log_idx[n0], 1);
    check("R4 reload after clear", log_val[n0], 105);

    // R5: alert outranks ready on the same unit, timeout kind
    n0 = log_n;
    pulse_alert(4'b1000, 4'b1000, 4'b1000);
    wait_valid();
    check("R5 priority valid", out_valid, 1);
    check("R5 priority seed", out_seed, 103);
    check("R5 kind timeout", out_kind, 1);
    check("R5 not loaded while alerted", log_n - n0, 0);
    cyc(8);
    check("R5 reload after clear count", log_n - n0, 1);
    check("R5 reload index", log_idx[n0], 3);
    check("R4 reload seed after priority", log_val[n0], 106);

    // R2 R4: sweep of bases including counter wrap
    foreach (bases[b]) begin
      n0 = log_n;
      do_start(bases[b], 1'b0, 4'hF);
      cyc(8);
      check("R2 sweep load count", log_n - n0, 4);
      seen = '0;
      for (int k = 0; k < 4; k++) begin
        check("R4 sweep seed", log_val[n0 + k], W'(bases[b] + W'(k)));
        seen[log_idx[n0 + k]] = 1'b1;
      end
      check("R3 sweep distinct units", seen, 4'hF);
    end

    // R8: barrier mode
    n0 = log_n;
    do_start(16'd500, 1'b1, '0);
    pulse_ready(4'b0111);
    cyc(12);
    check("R8 no load with one unit busy", log_n - n0, 0);
    pulse_ready(4'b1000);
    cyc(12);
    check("R8 barrier load count", log_n - n0, 4);
    seen = '0;
    for (int k = 0; k < 4; k++) begin
      check("R8 barrier seed", log_val[n0 + k], 500 + k);
      seen[log_idx[n0 + k]] = 1'b1;
    end
    check("R8 each unit once", seen, 4'hF);
    n0 = log_n;
    pulse_ready(4'b0001);
    cyc(12);
    check("R8 barrier closed after sweep", log_n - n0, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule